// File: doc/BRIEF.md
# Seven-to-One Video Lane Serializer

This block turns a 28-bit parallel video word into five serial lanes. Four lanes carry data and one carries a forwarded clock. One word is captured on each pixel clock cycle. The word holds eight bits each of red, green and blue, plus horizontal sync, vertical sync, data-enable and one reserved bit. A strap input chooses which edge of the pixel clock captures the word. The captured word is spread over the four data lanes at seven bits per lane. A bit clock, supplied by an external PLL at exactly seven times the pixel rate, shifts the bits out. The fifth lane repeats a fixed seven-bit shape in step with every data frame, so a receiver can find frame boundaries and recover the pixel rate.

Each pixel clock edge that captures a word flips a toggle. A two-stage synchronizer carries that toggle into the bit clock domain, and every toggle edge it detects starts a new frame. The same detection clears a watchdog counter. If the pixel clock stops, the counter expires and the lanes stay low. An active-low power-down input acts as the reset. It drops the output enable and clears the lanes. Power-down and the clocks may come and go in any order. Serialization restarts by itself from the first word captured after the clock is present again.

Top module: `lvser_tx`

## Requirements
- R1: Every frame carries all 28 bits of one captured word. Bit layout of `pix_i`: [7:0] red, [15:8] green, [23:16] blue, [24] hsync, [25] vsync, [26] data-enable, [27] reserved.
- R2: Each lane sends its seven bits most significant first, from these slots:
  - lane 0 = {G0, R5..R0}
  - lane 1 = {B1, B0, G5..G1}
  - lane 2 = {DE, VS, HS, B5..B2}
  - lane 3 = {RSV, B7, B6, G7, G6, R7, R6}
- R3: In every frame, the clock lane sends the pattern 1100011, first bit first, in the same seven bit-clock cycles as the data lanes.
- R4: With `edge_sel_i` high, the word is captured on the rising pixel clock edge. With it low, the word is captured on the falling edge.
- R5: The first bit of a frame appears on the lanes after the third bit-clock rising edge that follows its capture edge. The seventh bit appears after the ninth such edge. Frames follow each other every seven bit-clock cycles.
- R6: While `pd_n_i` is low, `oe_o` is low and all five lanes are low from the next bit-clock edge on. While `pd_n_i` is high, `oe_o` is high from the next edge on.
- R7: If the pixel clock stops while `pd_n_i` is high, all five lanes fall low within the frame in progress and stay low. The block flags loss after 32 bit-clock cycles without a toggle. `oe_o` stays high throughout.
- R8: After power-down is released, or after the pixel clock returns, the lanes stay low until the first word has been captured. That word's frame then starts on a frame boundary, with the timing given in R5.
- R9: No ordering is needed between `pd_n_i` and the pixel clock. The clock may start before or after release. After the clock stops and restarts, frames resume without cycling `pd_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix_i | input | 1 | Pixel clock |
| clk_bit_i | input | 1 | Bit clock, seven times the pixel rate and phase-related to it |
| pd_n_i | input | 1 | Active-low power-down; acts as a synchronous reset in the bit clock domain |
| edge_sel_i | input | 1 | Capture edge strap: 1 = rising, 0 = falling |
| pix_i | input | 28 | Parallel video word (layout in R1) |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Serial forwarded-clock lane |
| oe_o | output | 1 | Output enable; low means the drivers are off |

## Verification
Timing is counted in bit-clock rising edges from the capture edge. The first bit of a frame is on the lanes after edge 3, and the frame is complete after edge 9. `oe_o` and the power-down clearing follow `pd_n_i` after one edge. The bench numbers every bit-clock rising edge and stamps each capture edge with that number. It samples the lanes on falling bit-clock edges. It recognizes a frame when the clock-lane history reads 1100011. The frame must then match the capture stamped exactly nine edges earlier, and the first non-zero lane sample after a start must fall exactly three edges after the first capture. Because the two clocks are offset, no pixel clock edge coincides with a bit-clock edge. This makes every expected cycle exact.

// File: rtl/lvser_pkg.sv
package lvser_pkg;

    localparam int NUM_LANES = 4;
    localparam int SLOT_BITS = 7;
    localparam int WORD_W    = NUM_LANES * SLOT_BITS;

    // Forwarded-clock lane shape, sent MSB first in every frame.
    localparam logic [SLOT_BITS-1:0] CLK_PATTERN = 7'b1100011;

    typedef struct packed {
        logic       rsv;
        logic       de;
        logic       vs;
        logic       hs;
        logic [7:0] b;
        logic [7:0] g;
        logic [7:0] r;
    } pixel_t;

    typedef logic [NUM_LANES-1:0][SLOT_BITS-1:0] frame_t;

    typedef enum logic {TX_QUIET, TX_RUN} tx_state_e;

    // Distributes one word over the data lanes; bit 6 of each slot goes out first.
    function automatic frame_t map_lanes(pixel_t p);
        frame_t f;
        f[0] = {p.g[0], p.r[5:0]};
        f[1] = {p.b[1:0], p.g[5:1]};
        f[2] = {p.de, p.vs, p.hs, p.b[5:2]};
        f[3] = {p.rsv, p.b[7:6], p.g[7:6], p.r[7:6]};
        return f;
    endfunction

endpackage

// File: rtl/lvser_capture.sv
module lvser_capture
    import lvser_pkg::*;
(
    input  logic   clk_pix,
    input  logic   edge_sel,
    input  pixel_t pix_i,
    output pixel_t word_o,
    output logic   tog_o
);

    // The pixel domain has no reset: a missing clock could never apply it.
    pixel_t rise_q;
    pixel_t fall_q;
    logic   rise_tog = 1'b0;
    logic   fall_tog = 1'b0;

    always_ff @(posedge clk_pix) begin
        rise_q   <= pix_i;
        rise_tog <= ~rise_tog;
    end

    always_ff @(negedge clk_pix) begin
        fall_q   <= pix_i;
        fall_tog <= ~fall_tog;
    end

    // Word and toggle come from the same edge, so the word is stable for
    // a full pixel period after the toggle moves.
    assign word_o = edge_sel ? rise_q   : fall_q;
    assign tog_o  = edge_sel ? rise_tog : fall_tog;

endmodule

// File: rtl/lvser_clk_monitor.sv
module lvser_clk_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIMIT  = 32
) (
    input  logic clk_bit,
    input  logic rst,
    input  logic tog_i,
    output logic edge_o,
    output logic lost_o
);

    localparam int CNT_W = $clog2(LOSS_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOSS_LIMIT);

    // Synchronizer plus one history stage; it keeps running in power-down,
    // so no stale edge appears at release.
    logic [SYNC_STAGES:0] sync_q = '0;
    logic [CNT_W-1:0]     idle_q;

    always_ff @(posedge clk_bit) begin
        sync_q <= {sync_q[SYNC_STAGES-1:0], tog_i};
    end

    assign edge_o = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            idle_q <= CNT_MAX;
        end else if (edge_o) begin
            idle_q <= '0;
        end else if (idle_q != CNT_MAX) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign lost_o = (idle_q == CNT_MAX);

endmodule

// File: rtl/lvser_shifter.sv
module lvser_shifter
    import lvser_pkg::*;
(
    input  logic                 clk_bit,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic                 lost_i,
    input  pixel_t               word_i,
    output logic [NUM_LANES-1:0] lanes_o,
    output logic                 clk_lane_o,
    output logic                 running_o
);

    tx_state_e          state_q;
    frame_t             frame;
    logic [NUM_LANES:0] msb;

    assign frame = map_lanes(word_i);

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            state_q <= TX_QUIET;
        end else if (load_i) begin
            state_q <= TX_RUN;
        end else if (state_q == TX_RUN && lost_i) begin
            state_q <= TX_QUIET;
        end
    end

    // Slots 0..NUM_LANES-1 carry data; the last slot carries the clock shape.
    for (genvar i = 0; i <= NUM_LANES; i++) begin : g_lane
        logic [SLOT_BITS-1:0] fill;
        logic [SLOT_BITS-1:0] sh_q;

        if (i < NUM_LANES) begin : g_data
            assign fill = frame[i];
        end else begin : g_clk
            assign fill = CLK_PATTERN;
        end

        always_ff @(posedge clk_bit) begin
            if (rst) begin
                sh_q <= '0;
            end else if (load_i) begin
                sh_q <= fill;
            end else if (state_q == TX_RUN && !lost_i) begin
                sh_q <= {sh_q[SLOT_BITS-2:0], 1'b0};
            end else begin
                sh_q <= '0;
            end
        end

        assign msb[i] = sh_q[SLOT_BITS-1];
    end

    assign lanes_o    = msb[NUM_LANES-1:0];
    assign clk_lane_o = msb[NUM_LANES];
    assign running_o  = (state_q == TX_RUN);

endmodule

// File: rtl/lvser_tx.sv
module lvser_tx
    import lvser_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIMIT  = 32
) (
    input  logic                 clk_pix_i,
    input  logic                 clk_bit_i,
    input  logic                 pd_n_i,
    input  logic                 edge_sel_i,
    input  logic [WORD_W-1:0]    pix_i,
    output logic [NUM_LANES-1:0] lane_o,
    output logic                 clk_lane_o,
    output logic                 oe_o
);

    logic   rst;
    pixel_t word;
    logic   tog;
    logic   load;
    logic   lost;
    logic   running;
    logic   oe_q;

    // Power-down is the block reset.
    assign rst = ~pd_n_i;

    lvser_capture u_capture (
        .clk_pix  (clk_pix_i),
        .edge_sel (edge_sel_i),
        .pix_i    (pixel_t'(pix_i)),
        .word_o   (word),
        .tog_o    (tog)
    );

    lvser_clk_monitor #(
        .SYNC_STAGES (SYNC_STAGES),
        .LOSS_LIMIT  (LOSS_LIMIT)
    ) u_monitor (
        .clk_bit (clk_bit_i),
        .rst     (rst),
        .tog_i   (tog),
        .edge_o  (load),
        .lost_o  (lost)
    );

    lvser_shifter u_shifter (
        .clk_bit    (clk_bit_i),
        .rst        (rst),
        .load_i     (load),
        .lost_i     (lost),
        .word_i     (word),
        .lanes_o    (lane_o),
        .clk_lane_o (clk_lane_o),
        .running_o  (running)
    );

    always_ff @(posedge clk_bit_i) begin
        if (rst) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= 1'b1;
        end
    end

    assign oe_o = oe_q;

endmodule

// File: rtl/lvser_tx_checks.sv
module lvser_tx_checks #(
    parameter int NL = 4
) (
    input logic          clk_bit,
    input logic          pd_n,
    input logic [NL-1:0] lanes,
    input logic          clk_lane,
    input logic          oe,
    input logic          load,
    input logic          lost,
    input logic          running
);

    logic seen = 1'b0;

    always_ff @(posedge clk_bit) begin
        seen <= 1'b1;
    end

    // R6: power-down turns the drivers off and clears every lane
    a_r6_pd_off: assert property (@(posedge clk_bit) disable iff (!seen)
        !pd_n |=> (!oe && lanes == '0 && !clk_lane));

    // R6: released power-down enables the drivers
    a_r6_oe_on: assert property (@(posedge clk_bit) disable iff (!seen)
        pd_n |=> oe);

    // R3: every loaded frame starts the clock lane with 1, 1, 0
    a_r3_clk_shape: assert property (@(posedge clk_bit) disable iff (!pd_n)
        load |=> clk_lane ##1 clk_lane ##1 !clk_lane);

    // R7: a flagged clock loss keeps all lanes low
    a_r7_loss_low: assert property (@(posedge clk_bit) disable iff (!pd_n)
        lost |-> (lanes == '0 && !clk_lane));

    // R8: nothing leaves the block before the first captured word is loaded
    a_r8_quiet_low: assert property (@(posedge clk_bit) disable iff (!pd_n)
        !running |-> (lanes == '0 && !clk_lane));

endmodule

bind lvser_tx lvser_tx_checks #(.NL(lvser_pkg::NUM_LANES)) u_checks (
    .clk_bit  (clk_bit_i),
    .pd_n     (pd_n_i),
    .lanes    (lane_o),
    .clk_lane (clk_lane_o),
    .oe       (oe_o),
    .load     (load),
    .lost     (lost),
    .running  (running)
);

// File: tb/tb_lvser_tx.sv
module tb_lvser_tx;

    localparam int CAPN  = 32;
    localparam int LAT   = 9;   // capture edge to last bit of frame (R5)
    localparam int FIRST = 3;   // capture edge to first bit of frame (R5)

    logic        clk_pix, clk_bit, pd_n, edge_sel, pix_run;
    logic [27:0] pix;
    logic [3:0]  lane;
    logic        clk_lane, oe;

    int checks = 0, fails = 0, stamp = 0, seq = 0, gen_mode = 0;
    int cap_wr = 0, rx_count = 0, first_active = 0, first_cap = 0;
    bit mon_on = 0, arm_active = 0, arm_cap = 0, done = 0;
    logic [27:0] cap_word  [CAPN];
    int          cap_stamp [CAPN];
    logic [6:0]  hist [4];
    logic [6:0]  hist_c = '0;

    lvser_tx dut (
        .clk_pix_i  (clk_pix),
        .clk_bit_i  (clk_bit),
        .pd_n_i     (pd_n),
        .edge_sel_i (edge_sel),
        .pix_i      (pix),
        .lane_o     (lane),
        .clk_lane_o (clk_lane),
        .oe_o       (oe)
    );

    // 100 MHz bit clock; rising edges at 5 mod 10 ns
    initial begin
        clk_bit = 1'b0;
        forever #5 clk_bit = ~clk_bit;
    end

    // Pixel clock at 1/7 rate, edges at 2 and 7 mod 10 ns, gated by pix_run
    initial begin
        clk_pix = 1'b0;
        #2;
        forever begin
            if (pix_run) clk_pix = 1'b1;
            #35;
            clk_pix = 1'b0;
            #35;
        end
    end

    always @(posedge clk_bit) stamp++;

    function automatic logic [27:0] gen_word(int mode, int s);
        case (mode)
            1:       return 28'(1) << (s % 28);
            2:       return (s % 2 == 1) ? 28'hFFFFFFF : 28'h0;
            default: return 28'(s * 32'h9E3779B1) ^ 28'(s << 7);
        endcase
    endfunction

    // Expected slot contents, first-sent bit in position 6 (R2)
    function automatic logic [6:0] exp_slot(logic [27:0] w, int ln);
        case (ln)
            0:       return {w[8], w[5:0]};
            1:       return {w[17:16], w[13:9]};
            2:       return {w[26], w[25], w[24], w[21:18]};
            default: return {w[27], w[23:22], w[15:14], w[7:6]};
        endcase
    endfunction

    // Input changes on the edge opposite to the capture edge
    always @(posedge clk_pix) if (!edge_sel) begin
        #1; pix = gen_word(gen_mode, seq); seq++;
    end
    always @(negedge clk_pix) if (edge_sel) begin
        #1; pix = gen_word(gen_mode, seq); seq++;
    end

    task automatic log_cap();
        cap_word[cap_wr]  = pix;
        cap_stamp[cap_wr] = stamp;
        cap_wr = (cap_wr + 1) % CAPN;
        if (arm_cap) begin
            first_cap = stamp;
            arm_cap = 0;
        end
    endtask

    always @(posedge clk_pix) if (edge_sel)  log_cap();
    always @(negedge clk_pix) if (!edge_sel) log_cap();

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Frame monitor: a clock-lane window of 1100011 marks a complete frame
    always @(negedge clk_bit) begin
        bit found;
        bit bad;
        logic [27:0] w;
        found = 0;
        bad = 0;
        w = '0;
        for (int i = 0; i < 4; i++) hist[i] = {hist[i][5:0], lane[i]};
        hist_c = {hist_c[5:0], clk_lane};
        if (arm_active && (lane != 4'h0 || clk_lane)) begin
            first_active = stamp;
            arm_active = 0;
        end
        if (mon_on && hist_c == 7'b1100011) begin
            for (int k = 0; k < CAPN; k++)
                if (cap_stamp[k] == stamp - LAT) begin
                    found = 1;
                    w = cap_word[k];
                end
            rx_count++;
            checks++;
            if (!found) begin
                fails++;
                $display("FAIL R5 frame ending cycle %0d: actual no capture at %0d, expected one",
                         stamp, stamp - LAT);
            end else begin
                for (int ln = 0; ln < 4; ln++)
                    if (hist[ln] != exp_slot(w, ln)) bad = 1;
                if (bad) begin
                    fails++;
                    $display("FAIL R1,R2 lanes for word %h: actual %h expected %h", w,
                             {hist[3], hist[2], hist[1], hist[0]},
                             {exp_slot(w, 3), exp_slot(w, 2), exp_slot(w, 1), exp_slot(w, 0)});
                end
            end
        end
    end

    // Release power-down well clear of the last capture, then arm the start checks
    task automatic release_aligned();
        if (edge_sel) @(posedge clk_pix);
        else          @(negedge clk_pix);
        repeat (4) @(negedge clk_bit);
        pd_n = 1'b1;
        arm_cap = 1;
        arm_active = 1;
    endtask

    task automatic t_reset_state();
        repeat (10) @(negedge clk_bit);
        chk(oe == 1'b0, "R6", "oe during power-down", oe, 0);
        chk(lane == 4'h0 && !clk_lane, "R6", "lanes during power-down", {clk_lane, lane}, 0);
    endtask

    task automatic t_stream(input bit sel, input int mode, input int n, input string req);
        int rx0;
        @(negedge clk_bit);
        pd_n = 1'b0;
        edge_sel = sel;
        gen_mode = mode;
        repeat (12) @(negedge clk_bit);
        chk(oe == 1'b0 && lane == 4'h0 && !clk_lane, "R6", "off while mode changes",
            {oe, clk_lane, lane}, 0);
        rx0 = rx_count;
        mon_on = 1;
        release_aligned();
        repeat (n * 7) @(negedge clk_bit);
        chk(oe == 1'b1, "R6", "oe after release", oe, 1);
        chk(first_active - first_cap == FIRST, "R8", "first bit after first capture",
            first_active - first_cap, FIRST);
        // R3: clock-lane frames recognized in step with data; R4 via stamp match
        chk(rx_count - rx0 >= n - 3, req, "frames decoded", rx_count - rx0, n - 3);
    endtask

    task automatic t_pd_mid();
        int rx0;
        gen_mode = 0;
        repeat (40) @(negedge clk_bit);
        pd_n = 1'b0;
        @(negedge clk_bit);
        chk(oe == 1'b0 && lane == 4'h0 && !clk_lane, "R6", "off one edge after power-down",
            {oe, clk_lane, lane}, 0);
        repeat (20) @(negedge clk_bit);
        rx0 = rx_count;
        release_aligned();
        repeat (140) @(negedge clk_bit);
        chk(first_active - first_cap == FIRST, "R9", "restart latency after mid-stream power-down",
            first_active - first_cap, FIRST);
        chk(rx_count - rx0 >= 17, "R9", "frames after mid-stream power-down", rx_count - rx0, 17);
    endtask

    task automatic t_clock_loss();
        bit ok;
        int rx0;
        ok = 1;
        pix_run = 1'b0;
        repeat (45) @(negedge clk_bit);
        repeat (30) begin
            @(negedge clk_bit);
            if (lane != 4'h0 || clk_lane || !oe) ok = 0;
        end
        chk(ok, "R7", "lanes low, oe high with clock stopped", {oe, clk_lane, lane}, 16);
        rx0 = rx_count;
        arm_cap = 1;
        arm_active = 1;
        pix_run = 1'b1;
        repeat (140) @(negedge clk_bit);
        chk(first_active - first_cap == FIRST, "R8", "first bit after clock returns",
            first_active - first_cap, FIRST);
        chk(rx_count - rx0 >= 17, "R9", "frames resume without power-down", rx_count - rx0, 17);
    endtask

    task automatic t_late_clock();
        bit ok;
        int rx0;
        ok = 1;
        @(negedge clk_bit);
        pix_run = 1'b0;
        pd_n = 1'b0;
        repeat (20) @(negedge clk_bit);
        pd_n = 1'b1;
        repeat (60) begin
            @(negedge clk_bit);
            if (lane != 4'h0 || clk_lane || !oe) ok = 0;
        end
        chk(ok, "R8", "quiet after release with no clock", {oe, clk_lane, lane}, 16);
        rx0 = rx_count;
        arm_cap = 1;
        arm_active = 1;
        pix_run = 1'b1;
        repeat (140) @(negedge clk_bit);
        chk(first_active - first_cap == FIRST, "R8", "first bit when clock starts late",
            first_active - first_cap, FIRST);
        chk(rx_count - rx0 >= 17, "R9", "frames with clock started after release",
            rx_count - rx0, 17);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) hist[i] = '0;
        for (int k = 0; k < CAPN; k++) begin
            cap_word[k]  = '0;
            cap_stamp[k] = -1000;
        end
        pd_n = 1'b0;
        edge_sel = 1'b1;
        pix_run = 1'b1;
        pix = '0;
        t_reset_state();
        t_stream(1'b1, 1, 30, "R4");
        t_stream(1'b0, 0, 24, "R4");
        t_stream(1'b0, 1, 30, "R3");
        t_stream(1'b1, 2, 16, "R1");
        t_pd_mid();
        t_clock_loss();
        t_late_clock();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual run still active, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule